// File: doc/BRIEF.md
# Integer Load/Store Address Generator and Beat Sequencer

This block sits between instruction issue and a simple memory port, and handles every integer load and store. It accepts one memory operation at a time with the register operand values already read. It adds the base to either a sign-extended immediate or an index register to form the effective address (EA). Illegal register combinations are rejected before any memory traffic. The block then drives one doubleword-wide memory beat, or two for a quadword, and returns results through a single register write port: load data with zero or sign extension, and the updated base for update forms.

A quadword moves as two doubleword beats at EA and EA+8. The two registers of the pair, `rt` and `rt+1`, are steered to those beats in an order that depends on the endianness mode and on whether the operation is the prefixed form. Sub-doubleword accesses use byte lanes: the lane offset is the low three bits of the EA, and the byte enables and data are shifted to match.

Top module: `lsu_agen_seq`

## Requirements
- R1: EA = base + offset. The base is `base_val`, or zero when `op_ra` is 0. The offset is `index_val` when `op_indexed` = 1, otherwise `op_imm` sign-extended to 64 bits. For a single-beat operation, `mem_req_addr` equals EA.
- R2: An update operation (`op_update` = 1, not quadword) with `op_ra` = 0 raises `illegal` for one cycle, in the cycle after acceptance. It makes no memory request and no register write.
- R3: An update load (`op_store` = 0) with `op_ra` = `op_rt` is illegal in the same way as R2. An update store with `op_ra` = `op_rt` is legal.
- R4: When a legal update operation finishes, EA is written to register `op_ra`. For a load, this write comes in a later cycle than the load-data write to `op_rt`.
- R5: `op_size` encodes the access size: 0 = byte, 1 = halfword, 2 = word, 3 = doubleword. `mem_req_be` is (2^bytes − 1) shifted left by EA[2:0]. Store data from `src_lo` is shifted left by 8·EA[2:0].
- R6: Load data is `mem_rsp_data` shifted right by 8·EA[2:0], then extended to 64 bits. Halfword and word loads sign-extend when `op_signed` = 1 and zero-extend otherwise. Byte loads always zero-extend, so `op_signed` has no effect on them.
- R7: A quadword (`op_quad` = 1) issues two doubleword beats, the first at EA and the second at EA+8, each with `mem_req_be` = 0xFF.
- R8: Pair steering for a quadword. Normally, the EA beat carries register `op_rt` (`src_lo` for stores) and the EA+8 beat carries `op_rt+1` (`src_hi`), with the index taken modulo 32. When `op_le` = 1 and `op_prefixed` = 0, the pair is swapped.
- R9: A quadword load with `op_ra` = `op_rt` is illegal, as in R2. A quadword store with the same registers is legal.
- R10: `op_ready` is high only while the block is idle. A memory request that is not accepted keeps its valid, address and write flag unchanged until `mem_req_ready` is high. After reset, `op_ready` = 1 and `mem_req_valid` = `rf_we` = 0.
- R11: A quadword ignores `op_update` and never writes the base register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Operation offered |
| op_ready | output | 1 | Block idle, operation accepted |
| op_store | input | 1 | 1 = store, 0 = load |
| op_size | input | 2 | Access size code (R5) |
| op_signed | input | 1 | Sign-extend the load result |
| op_update | input | 1 | Write EA back to the base register |
| op_indexed | input | 1 | Offset from index register instead of immediate |
| op_quad | input | 1 | Quadword pair access |
| op_prefixed | input | 1 | Prefixed form (disables little-endian pair swap) |
| op_le | input | 1 | Little-endian mode |
| op_ra | input | 5 | Base register index |
| op_rt | input | 5 | Target/source register index |
| op_imm | input | 16 | Displacement |
| base_val | input | 64 | Contents of register ra |
| index_val | input | 64 | Contents of index register |
| src_lo | input | 64 | Contents of register rt |
| src_hi | input | 64 | Contents of register rt+1 |
| mem_req_valid | output | 1 | Memory beat request |
| mem_req_ready | input | 1 | Memory accepts request |
| mem_req_we | output | 1 | Beat is a write |
| mem_req_addr | output | 64 | Beat address |
| mem_req_be | output | 8 | Byte enables |
| mem_req_wdata | output | 64 | Write data, lane aligned |
| mem_rsp_valid | input | 1 | Read data returned |
| mem_rsp_data | input | 64 | Read data |
| rf_we | output | 1 | Register write strobe |
| rf_waddr | output | 5 | Register write index |
| rf_wdata | output | 64 | Register write data |
| illegal | output | 1 | Illegal-form pulse |

## Verification
Two results can collide on the single write port in the same cycle: the returned data of an update load, and the EA write-back to its base register. The bench provokes this with update loads whose memory response arrives immediately, with random delays, and with random back-pressure on `mem_req_ready`. It records every register write in order and expects exactly two writes: the extended data to `rt` first, then EA to `ra`. A lost, merged or reordered write therefore shows up as a mismatch.

// File: rtl/lsu_pkg.sv
package lsu_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_DBL  = 2'd3
    } acc_size_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_BEAT,
        ST_WAIT,
        ST_UPD
    } seq_state_e;

    typedef struct packed {
        logic      store;
        acc_size_e size;
        logic      sgn;
        logic      upd;
        logic      idx_form;
        logic      quad;
        logic      prefixed;
        logic      le;
    } op_ctl_t;

    // Pair is swapped only for the little-endian, non-prefixed quad form
    function automatic logic pair_swapped(input op_ctl_t c);
        return c.le && !c.prefixed;
    endfunction

endpackage

// File: rtl/lsu_ea_gen.sv
module lsu_ea_gen
    import lsu_pkg::*;
#(
    parameter int XLEN  = 64,
    parameter int RA_W  = 5,
    parameter int IMM_W = 16
) (
    input  op_ctl_t          ctl,
    input  logic [RA_W-1:0]  ra,
    input  logic [RA_W-1:0]  rt,
    input  logic [IMM_W-1:0] imm,
    input  logic [XLEN-1:0]  base_val,
    input  logic [XLEN-1:0]  index_val,
    output logic [XLEN-1:0]  ea,
    output logic             bad_form
);
    localparam int EXT_W = XLEN - IMM_W;

    logic [XLEN-1:0] base_eff;
    logic [XLEN-1:0] offset;
    logic            ra_zero;
    logic            ra_is_rt;

    assign ra_zero  = (ra == '0);
    assign ra_is_rt = (ra == rt);
    assign base_eff = ra_zero ? '0 : base_val;
    assign offset   = ctl.idx_form ? index_val : {{EXT_W{imm[IMM_W-1]}}, imm};
    assign ea       = base_eff + offset;

    always_comb begin
        bad_form = 1'b0;
        if (ctl.quad) begin
            bad_form = !ctl.store && ra_is_rt;
        end else if (ctl.upd) begin
            bad_form = ra_zero || (!ctl.store && ra_is_rt);
        end
    end

endmodule

// File: rtl/lsu_lane_unit.sv
module lsu_lane_unit
    import lsu_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  acc_size_e              size,
    input  logic                   sgn,
    input  logic [$clog2(XLEN/8)-1:0] lane,
    input  logic [XLEN-1:0]        st_data,
    input  logic [XLEN-1:0]        rsp_data,
    output logic [XLEN/8-1:0]      be,
    output logic [XLEN-1:0]        wdata,
    output logic [XLEN-1:0]        ld_data
);
    localparam int LANES = XLEN / 8;
    localparam int OFF_W = $clog2(LANES);

    logic [LANES-1:0]  size_mask;
    logic [OFF_W+2:0]  bit_sh;
    logic [XLEN-1:0]   shifted;

    generate
        for (genvar i = 0; i < LANES; i++) begin : g_mask
            assign size_mask[i] = (i < (1 << size));
        end
    endgenerate

    assign bit_sh  = {lane, 3'b000};
    assign be      = size_mask << lane;
    assign wdata   = st_data << bit_sh;
    assign shifted = rsp_data >> bit_sh;

    always_comb begin
        unique case (size)
            SZ_BYTE: ld_data = {{(XLEN-8){1'b0}}, shifted[7:0]};
            SZ_HALF: ld_data = {{(XLEN-16){sgn & shifted[15]}}, shifted[15:0]};
            SZ_WORD: ld_data = {{(XLEN-32){sgn & shifted[31]}}, shifted[31:0]};
            default: ld_data = shifted;
        endcase
    end

endmodule

// File: rtl/lsu_agen_seq.sv
module lsu_agen_seq
    import lsu_pkg::*;
#(
    parameter int XLEN  = 64,
    parameter int RA_W  = 5,
    parameter int IMM_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              op_valid,
    output logic              op_ready,
    input  logic              op_store,
    input  logic [1:0]        op_size,
    input  logic              op_signed,
    input  logic              op_update,
    input  logic              op_indexed,
    input  logic              op_quad,
    input  logic              op_prefixed,
    input  logic              op_le,
    input  logic [RA_W-1:0]   op_ra,
    input  logic [RA_W-1:0]   op_rt,
    input  logic [IMM_W-1:0]  op_imm,
    input  logic [XLEN-1:0]   base_val,
    input  logic [XLEN-1:0]   index_val,
    input  logic [XLEN-1:0]   src_lo,
    input  logic [XLEN-1:0]   src_hi,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic              mem_req_we,
    output logic [XLEN-1:0]   mem_req_addr,
    output logic [XLEN/8-1:0] mem_req_be,
    output logic [XLEN-1:0]   mem_req_wdata,
    input  logic              mem_rsp_valid,
    input  logic [XLEN-1:0]   mem_rsp_data,
    output logic              rf_we,
    output logic [RA_W-1:0]   rf_waddr,
    output logic [XLEN-1:0]   rf_wdata,
    output logic              illegal
);
    localparam int LANES = XLEN / 8;
    localparam int OFF_W = $clog2(LANES);

    seq_state_e       state;
    op_ctl_t          ctl_in, ctl_q;
    logic [RA_W-1:0]  ra_q, rt_q;
    logic [XLEN-1:0]  ea_q, d_lo_q, d_hi_q;
    logic             beat_q;
    logic             illegal_q;

    logic [XLEN-1:0]  ea_w;
    logic             bad_w;

    always_comb begin
        ctl_in.store    = op_store;
        ctl_in.size     = op_quad ? SZ_DBL : acc_size_e'(op_size);
        ctl_in.sgn      = op_signed;
        ctl_in.upd      = op_update && !op_quad;
        ctl_in.idx_form = op_indexed;
        ctl_in.quad     = op_quad;
        ctl_in.prefixed = op_prefixed;
        ctl_in.le       = op_le;
    end

    lsu_ea_gen #(.XLEN(XLEN), .RA_W(RA_W), .IMM_W(IMM_W)) u_ea (
        .ctl       (ctl_in),
        .ra        (op_ra),
        .rt        (op_rt),
        .imm       (op_imm),
        .base_val  (base_val),
        .index_val (index_val),
        .ea        (ea_w),
        .bad_form  (bad_w)
    );

    // Beat-level steering
    logic             second_slot;
    logic [XLEN-1:0]  beat_addr;
    logic [XLEN-1:0]  beat_src;
    logic [RA_W-1:0]  beat_reg;
    logic [OFF_W-1:0] beat_lane;
    logic [XLEN-1:0]  ld_data;
    logic             more_beats;

    assign second_slot = ctl_q.quad && (beat_q ^ pair_swapped(ctl_q));
    assign beat_addr   = ea_q + (beat_q ? XLEN'(LANES) : '0);
    assign beat_src    = second_slot ? d_hi_q : d_lo_q;
    assign beat_reg    = second_slot ? rt_q + 1'b1 : rt_q;
    assign beat_lane   = ctl_q.quad ? '0 : beat_addr[OFF_W-1:0];
    assign more_beats  = ctl_q.quad && !beat_q;

    lsu_lane_unit #(.XLEN(XLEN)) u_lane (
        .size     (ctl_q.size),
        .sgn      (ctl_q.sgn),
        .lane     (beat_lane),
        .st_data  (beat_src),
        .rsp_data (mem_rsp_data),
        .be       (mem_req_be),
        .wdata    (mem_req_wdata),
        .ld_data  (ld_data)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            ctl_q     <= '0;
            ra_q      <= '0;
            rt_q      <= '0;
            ea_q      <= '0;
            d_lo_q    <= '0;
            d_hi_q    <= '0;
            beat_q    <= 1'b0;
            illegal_q <= 1'b0;
        end else begin
            illegal_q <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (op_valid) begin
                        ctl_q  <= ctl_in;
                        ra_q   <= op_ra;
                        rt_q   <= op_rt;
                        ea_q   <= ea_w;
                        d_lo_q <= src_lo;
                        d_hi_q <= src_hi;
                        beat_q <= 1'b0;
                        if (bad_w) illegal_q <= 1'b1;
                        else       state     <= ST_BEAT;
                    end
                end
                ST_BEAT: begin
                    if (mem_req_ready) begin
                        if (!ctl_q.store)    state  <= ST_WAIT;
                        else if (more_beats) beat_q <= 1'b1;
                        else if (ctl_q.upd)  state  <= ST_UPD;
                        else                 state  <= ST_IDLE;
                    end
                end
                ST_WAIT: begin
                    if (mem_rsp_valid) begin
                        if (more_beats) begin
                            beat_q <= 1'b1;
                            state  <= ST_BEAT;
                        end else if (ctl_q.upd) begin
                            state <= ST_UPD;
                        end else begin
                            state <= ST_IDLE;
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign op_ready      = (state == ST_IDLE);
    assign illegal       = illegal_q;
    assign mem_req_valid = (state == ST_BEAT);
    assign mem_req_we    = ctl_q.store;
    assign mem_req_addr  = beat_addr;
    assign rf_we         = (state == ST_UPD) || ((state == ST_WAIT) && mem_rsp_valid);
    assign rf_waddr      = (state == ST_UPD) ? ra_q : beat_reg;
    assign rf_wdata      = (state == ST_UPD) ? ea_q : ld_data;

endmodule

// File: rtl/lsu_agen_seq_chk.sv
module lsu_agen_seq_chk #(
    parameter int XLEN = 64
) (
    input logic              clk,
    input logic              rst,
    input logic              op_valid,
    input logic              op_ready,
    input logic              mem_req_valid,
    input logic              mem_req_ready,
    input logic              mem_req_we,
    input logic [XLEN-1:0]   mem_req_addr,
    input logic [XLEN/8-1:0] mem_req_be,
    input logic              rf_we,
    input logic              illegal
);
    // R10
    req_hold_chk: assert property (@(posedge clk) disable iff (rst)
        mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_we));

    // R10
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        op_ready |-> !mem_req_valid && !rf_we);

    // R2
    illegal_noop_chk: assert property (@(posedge clk) disable iff (rst)
        illegal |-> !mem_req_valid && !rf_we);

    // R3
    illegal_after_accept_chk: assert property (@(posedge clk) disable iff (rst)
        illegal |-> $past(op_valid && op_ready));

    // R5
    be_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
        mem_req_valid |-> mem_req_be != '0);

    // R4
    wb_apart_chk: assert property (@(posedge clk) disable iff (rst)
        rf_we |-> !mem_req_valid);
endmodule

bind lsu_agen_seq lsu_agen_seq_chk #(.XLEN(XLEN)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .op_valid      (op_valid),
    .op_ready      (op_ready),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_we    (mem_req_we),
    .mem_req_addr  (mem_req_addr),
    .mem_req_be    (mem_req_be),
    .rf_we         (rf_we),
    .illegal       (illegal)
);

// File: tb/lsu_agen_seq_tb.sv
`timescale 1ns/1ps
module lsu_agen_seq_tb;
    logic        clk = 1'b0;
    logic        rst;
    logic        op_valid, op_ready, op_store, op_signed, op_update, op_indexed;
    logic        op_quad, op_prefixed, op_le;
    logic [1:0]  op_size;
    logic [4:0]  op_ra, op_rt;
    logic [15:0] op_imm;
    logic [63:0] base_val, index_val, src_lo, src_hi;
    logic        mem_req_valid, mem_req_ready, mem_req_we;
    logic [63:0] mem_req_addr, mem_req_wdata;
    logic [7:0]  mem_req_be;
    logic        mem_rsp_valid;
    logic [63:0] mem_rsp_data;
    logic        rf_we;
    logic [4:0]  rf_waddr;
    logic [63:0] rf_wdata;
    logic        illegal;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    lsu_agen_seq u_dut (
        .clk(clk), .rst(rst), .op_valid(op_valid), .op_ready(op_ready),
        .op_store(op_store), .op_size(op_size), .op_signed(op_signed),
        .op_update(op_update), .op_indexed(op_indexed), .op_quad(op_quad),
        .op_prefixed(op_prefixed), .op_le(op_le), .op_ra(op_ra), .op_rt(op_rt),
        .op_imm(op_imm), .base_val(base_val), .index_val(index_val),
        .src_lo(src_lo), .src_hi(src_hi), .mem_req_valid(mem_req_valid),
        .mem_req_ready(mem_req_ready), .mem_req_we(mem_req_we),
        .mem_req_addr(mem_req_addr), .mem_req_be(mem_req_be),
        .mem_req_wdata(mem_req_wdata), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_data(mem_rsp_data), .rf_we(rf_we), .rf_waddr(rf_waddr),
        .rf_wdata(rf_wdata), .illegal(illegal)
    );

    function automatic logic [63:0] exp_load(input logic [1:0] sz, input bit sgn,
                                             input logic [63:0] raw, input int lane);
        logic [63:0] s;
        s = raw >> (8 * lane);
        case (sz)
            2'd0:    return {56'd0, s[7:0]};
            2'd1:    return sgn ? {{48{s[15]}}, s[15:0]} : {48'd0, s[15:0]};
            2'd2:    return sgn ? {{32{s[31]}}, s[31:0]} : {32'd0, s[31:0]};
            default: return s;
        endcase
    endfunction

    // expected / observed event lists
    logic [63:0] e_addr [4], o_addr [4], e_wd [4], o_wd [4], e_rd [4], o_rd [4];
    logic [7:0]  e_be [4], o_be [4];
    logic        e_we [4], o_we [4];
    logic [4:0]  e_ra [4], o_ra [4];
    int e_nreq, o_nreq, e_nwr, o_nwr, e_ill, o_ill;

    task automatic report(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
        failures++;
        $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    endtask

    task automatic run_op(input string tag, input bit st, input logic [1:0] sz, input bit sgn,
                          input bit upd, input bit idxf, input bit quad, input bit pre, input bit le,
                          input logic [4:0] ra, input logic [4:0] rt,
                          input logic [63:0] base, input logic [63:0] idxv, input logic [15:0] imm,
                          input logic [63:0] v0, input logic [63:0] v1,
                          input logic [63:0] p0, input logic [63:0] p1);
        logic [63:0] ea, raw;
        bit bad, swp, pend, ok;
        int cnt, pidx, nld, lane, nb;
        logic [63:0] pats [2];
        pats[0] = p0; pats[1] = p1;
        // expected
        ea = ((ra == 0) ? 64'd0 : base) + (idxf ? idxv : {{48{imm[15]}}, imm});
        bad = quad ? (!st && ra == rt) : (upd && (ra == 0 || (!st && ra == rt)));
        swp = le && !pre;
        e_nreq = 0; e_nwr = 0; e_ill = bad ? 1 : 0;
        lane = int'(ea[2:0]);
        if (!bad) begin
            if (quad) begin
                for (int b = 0; b < 2; b++) begin
                    e_addr[b] = ea + 64'(8 * b); e_be[b] = 8'hFF; e_we[b] = st;
                    e_wd[b] = ((b == 1) ^ swp) ? v1 : v0;
                    if (!st) begin
                        e_ra[e_nwr] = ((b == 1) ^ swp) ? rt + 5'd1 : rt;
                        e_rd[e_nwr] = pats[b]; e_nwr++;
                    end
                end
                e_nreq = 2;
            end else begin
                nb = 1 << sz;
                e_addr[0] = ea; e_we[0] = st;
                e_be[0] = 8'(((1 << nb) - 1) << lane);
                e_wd[0] = v0 << (8 * lane);
                e_nreq = 1;
                if (!st) begin e_ra[0] = rt; e_rd[0] = exp_load(sz, sgn, p0, lane); e_nwr = 1; end
                if (upd) begin e_ra[e_nwr] = ra; e_rd[e_nwr] = ea; e_nwr++; end
            end
        end
        // drive
        @(negedge clk);
        op_valid = 1; op_store = st; op_size = sz; op_signed = sgn; op_update = upd;
        op_indexed = idxf; op_quad = quad; op_prefixed = pre; op_le = le;
        op_ra = ra; op_rt = rt; base_val = base; index_val = idxv; op_imm = imm;
        src_lo = v0; src_hi = v1;
        o_nreq = 0; o_nwr = 0; o_ill = 0; pend = 0; cnt = 0; pidx = 0; nld = 0;
        @(negedge clk);
        op_valid = 0;
        for (int cyc = 1; cyc < 60; cyc++) begin
            mem_req_ready = ($urandom % 3) != 0;
            if (pend && cnt == 0) begin
                mem_rsp_valid = 1; mem_rsp_data = pats[pidx]; pend = 0;
            end else begin
                mem_rsp_valid = 0; mem_rsp_data = $urandom;
                if (pend) cnt--;
            end
            #1;
            if (mem_req_valid && mem_req_ready) begin
                if (o_nreq < 4) begin
                    o_addr[o_nreq] = mem_req_addr; o_be[o_nreq] = mem_req_be;
                    o_we[o_nreq] = mem_req_we; o_wd[o_nreq] = mem_req_wdata;
                end
                o_nreq++;
                if (!mem_req_we) begin pend = 1; cnt = $urandom % 3; pidx = nld; nld = (nld + 1) % 2; end
            end
            if (rf_we) begin
                if (o_nwr < 4) begin o_ra[o_nwr] = rf_waddr; o_rd[o_nwr] = rf_wdata; end
                o_nwr++;
            end
            if (illegal) o_ill++;
            if (cyc >= 2 && op_ready && !pend) break;
            @(negedge clk);
        end
        mem_rsp_valid = 0;
        // compare
        checks++;
        ok = 1;
        if (o_ill != e_ill) begin report(tag, "illegal count", 64'(o_ill), 64'(e_ill)); ok = 0; end
        if (ok && o_nreq != e_nreq) begin report(tag, "request count", 64'(o_nreq), 64'(e_nreq)); ok = 0; end
        if (ok && o_nwr != e_nwr) begin report(tag, "write count", 64'(o_nwr), 64'(e_nwr)); ok = 0; end
        for (int i = 0; ok && i < e_nreq; i++) begin
            if (o_addr[i] != e_addr[i]) begin report(tag, "req addr", o_addr[i], e_addr[i]); ok = 0; end
            else if (o_be[i] != e_be[i]) begin report(tag, "req be", 64'(o_be[i]), 64'(e_be[i])); ok = 0; end
            else if (o_we[i] != e_we[i]) begin report(tag, "req we", 64'(o_we[i]), 64'(e_we[i])); ok = 0; end
            else if (st && o_wd[i] != e_wd[i]) begin report(tag, "req wdata", o_wd[i], e_wd[i]); ok = 0; end
        end
        for (int i = 0; ok && i < e_nwr; i++) begin
            if (o_ra[i] != e_ra[i]) begin report(tag, "wb index", 64'(o_ra[i]), 64'(e_ra[i])); ok = 0; end
            else if (o_rd[i] != e_rd[i]) begin report(tag, "wb data", o_rd[i], e_rd[i]); ok = 0; end
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL R10 watchdog expired actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        rst = 1; op_valid = 0; op_store = 0; op_size = 0; op_signed = 0; op_update = 0;
        op_indexed = 0; op_quad = 0; op_prefixed = 0; op_le = 0; op_ra = 0; op_rt = 0;
        op_imm = 0; base_val = 0; index_val = 0; src_lo = 0; src_hi = 0;
        mem_req_ready = 0; mem_rsp_valid = 0; mem_rsp_data = 0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 0;
        #1;
        // R10 reset state
        checks++;
        if (!(op_ready && !mem_req_valid && !rf_we && !illegal)) begin
            failures++;
            $display("FAIL R10 reset state actual=%b%b%b%b expected=1000", op_ready, mem_req_valid, rf_we, illegal);
        end
        // R1 base register 0 reads as zero, byte at lane 3 (R5)
        run_op("R1", 0, 2'd0, 0, 0, 0, 0, 0, 0, 5'd0, 5'd4, 64'hFFFF_0000_0000_0000, 0, 16'h1003,
               0, 0, 64'h0000_0000_AB00_0000, 0);
        // R1 negative immediate
        run_op("R1", 0, 2'd3, 0, 0, 0, 0, 0, 0, 5'd7, 5'd8, 64'h0000_0000_0001_0000, 0, 16'hFFF8,
               0, 0, 64'h1122_3344_5566_7788, 0);
        // R6 halfword sign and zero extension
        run_op("R6", 0, 2'd1, 1, 0, 0, 0, 0, 0, 5'd2, 5'd3, 64'h100, 0, 16'h0006,
               0, 0, 64'h8123_0000_0000_0000, 0);
        run_op("R6", 0, 2'd1, 0, 0, 0, 0, 0, 0, 5'd2, 5'd3, 64'h100, 0, 16'h0006,
               0, 0, 64'h8123_0000_0000_0000, 0);
        // R6 signed flag has no effect on bytes
        run_op("R6", 0, 2'd0, 1, 0, 0, 0, 0, 0, 5'd2, 5'd3, 64'h100, 0, 16'h0001,
               0, 0, 64'h0000_0000_0000_F000, 0);
        // R6 signed word in upper lane
        run_op("R6", 0, 2'd2, 1, 0, 1, 0, 0, 0, 5'd2, 5'd3, 64'h200, 64'h4, 0,
               0, 0, 64'h9000_0001_0000_0000, 0);
        // R4 update load indexed: data write then base write
        run_op("R4", 0, 2'd3, 0, 1, 1, 0, 0, 0, 5'd5, 5'd6, 64'h1000, 64'h40, 0,
               0, 0, 64'hDEAD_BEEF_0123_4567, 0);
        // R2 update with base 0
        run_op("R2", 1, 2'd0, 0, 1, 0, 0, 0, 0, 5'd0, 5'd6, 64'h1000, 0, 16'h10,
               64'h55, 0, 0, 0);
        // R3 update load ra==rt illegal, update store ra==rt legal
        run_op("R3", 0, 2'd2, 0, 1, 0, 0, 0, 0, 5'd9, 5'd9, 64'h1000, 0, 16'h8, 0, 0, 0, 0);
        run_op("R3", 1, 2'd2, 0, 1, 0, 0, 0, 0, 5'd9, 5'd9, 64'h1000, 0, 16'h4,
               64'h0000_0000_CAFE_F00D, 0, 0, 0);
        // R5 halfword store at lane 6
        run_op("R5", 1, 2'd1, 0, 0, 0, 0, 0, 0, 5'd1, 5'd2, 64'h2000, 0, 16'h0006,
               64'h0000_0000_0000_BEEF, 0, 0, 0);
        // R9 quad load ra==rt illegal, quad store ra==rt legal
        run_op("R9", 0, 2'd3, 0, 0, 0, 1, 0, 0, 5'd4, 5'd4, 64'h3000, 0, 0, 0, 0, 0, 0);
        run_op("R9", 1, 2'd3, 0, 0, 0, 1, 0, 0, 5'd4, 5'd4, 64'h3000, 0, 0,
               64'h1111, 64'h2222, 0, 0);
        // R7/R8 quad load, big-endian order
        run_op("R7", 0, 2'd3, 0, 0, 0, 1, 0, 0, 5'd1, 5'd10, 64'h4000, 0, 16'h10,
               0, 0, 64'hAAAA, 64'hBBBB);
        // R8 little-endian non-prefixed swap, prefixed no swap, store swap, wrap rt=31
        run_op("R8", 0, 2'd3, 0, 0, 0, 1, 0, 1, 5'd1, 5'd10, 64'h4000, 0, 16'h10,
               0, 0, 64'hAAAA, 64'hBBBB);
        run_op("R8", 0, 2'd3, 0, 0, 0, 1, 1, 1, 5'd1, 5'd31, 64'h4000, 0, 16'h10,
               0, 0, 64'hAAAA, 64'hBBBB);
        run_op("R8", 1, 2'd3, 0, 0, 0, 1, 0, 1, 5'd1, 5'd12, 64'h4000, 0, 16'h20,
               64'h1010, 64'h2020, 0, 0);
        // R11 quad ignores update bit
        run_op("R11", 0, 2'd3, 0, 1, 0, 1, 0, 0, 5'd0, 5'd12, 64'h0, 0, 16'h40,
               0, 0, 64'h77, 64'h88);
        // R1 random mix (covers R2..R11 collisions too)
        for (int n = 0; n < 400; n++) begin
            bit q, s;
            logic [1:0] z;
            logic [4:0] a, t;
            int ln;
            q = ($urandom % 5) == 0;
            s = $urandom % 2;
            z = q ? 2'd3 : 2'($urandom % 4);
            ln = q ? 0 : (int'($urandom % 8) & ~((1 << z) - 1));
            a = ($urandom % 2) ? 5'($urandom % 4) : 5'($urandom);
            t = ($urandom % 2) ? 5'($urandom % 4) : 5'($urandom);
            run_op("R1", s, z, $urandom % 2, $urandom % 2, $urandom % 2, q, $urandom % 2, $urandom % 2,
                   a, t, {$urandom, $urandom} & ~64'h7, {$urandom, 29'($urandom), 3'(ln)},
                   {13'($urandom), 3'(ln)}, {$urandom, $urandom}, {$urandom, $urandom},
                   {$urandom, $urandom}, {$urandom, $urandom});
        end
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule